// File: doc/BRIEF.md
# Two-Level Linear-to-Physical Address Walker

This block turns a 32-bit linear address into a 32-bit physical address. The linear address is cut into three parts: a 10-bit directory index, a 10-bit table index and a 12-bit byte offset. The walker reads one 32-bit entry from the page directory and then one 32-bit entry from the page table that the first entry points to. The physical address is the page base from the second entry joined with the unchanged offset. When translation is switched off, the linear address passes straight through and memory is not touched.

Each entry keeps its base address in bits 31:12 and control bits in bits 11:0. Only bit 0, the present flag, is used. If either entry is not present, the walk stops and reports a fault. The block accepts one request at a time through a valid/ready port. It issues single reads on a request/response memory port and reports each result as a one-cycle pulse.

Top module: `pgwalk_top`

## Requirements
- R1: When `xlat_en` is 0 at the moment a request is accepted, the result is `res_phys` equal to the linear address with `res_fault` 0, and no memory read is issued for that request.
- R2: The first read of a walk goes to address {dir_base[31:12], lin[31:22], 2'b00}. Bits 11:0 of `dir_base` have no effect.
- R3: The second read goes to address {dir_entry[31:12], lin[21:12], 2'b00}. Control bits 11:1 of the directory entry have no effect.
- R4: When bit 0 of both entries is 1, the result is {table_entry[31:12], lin[11:0]} with `res_fault` 0, after exactly two reads.
- R5: When bit 0 of the directory entry is 0, the walk ends after that single read with `res_fault` 1 and `res_phys` 0.
- R6: When bit 0 of the table entry is 0, the walk ends after two reads with `res_fault` 1 and `res_phys` 0.
- R7: `req_ready` is 1 only while the walker is idle. A request held valid during a walk is not taken, and the result belongs to the request that started the walk.
- R8: Once `mem_rd_valid` rises, it stays high and `mem_rd_addr` stays unchanged until a cycle with `mem_rd_ready` high. Each read is issued exactly once.
- R9: After reset, `req_ready` is 1 and both `mem_rd_valid` and `res_valid` are 0. Each `res_valid` pulse lasts exactly one cycle.
- R10: A `mem_rsp_valid` that arrives while no read is outstanding is ignored. It causes no result and does not affect the next walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| xlat_en | input | 1 | Translation switch, sampled when a request is accepted |
| dir_base | input | 32 | Page directory base; bits 31:12 are used |
| req_valid | input | 1 | Translation request valid |
| req_lin | input | 32 | Linear address to translate |
| req_ready | output | 1 | Walker can accept a request |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| res_valid | output | 1 | One-cycle result strobe |
| res_phys | output | 32 | Physical address, 0 on a fault |
| res_fault | output | 1 | Walk hit an entry whose present bit is 0 |

## Verification
The bench uses entries that have junk in their control bits and directory bases that have nonzero low bits. A design that let those bits into an address would read the wrong location or return the wrong page base. It covers a missing directory entry and a missing table entry separately. A walker that went on to the second read after a directory fault, or that returned a stale page base, would show the wrong read count or a nonzero address. It stalls the read handshake for several cycles and keeps a second request valid during a walk. A design that issued a read twice or took the second request would make extra reads or return the wrong offset. It also sends a stray memory response while the walker is idle. A design that consumed it would fault or mistranslate the next walk.

// File: rtl/pgw_pkg.sv
// Shared types for the address walker.
package pgw_pkg;
    // Walk phases: idle, directory read, table read, result
    typedef enum logic [1:0] {
        WALK_IDLE = 2'd0,
        WALK_DIR  = 2'd1,
        WALK_TBL  = 2'd2,
        WALK_DONE = 2'd3
    } walk_state_t;
endpackage

// File: rtl/pgw_seq.sv
// Walk sequencer: owns the phase, the one-read-outstanding flag and the
// fault flag. Assumes memory answers every accepted read with exactly one
// response, and answers it after the read is accepted.
module pgw_seq
    import pgw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        xlat_en,
    input  logic        rd_ready,
    input  logic        rsp_valid,
    input  logic        rsp_present,
    output walk_state_t state_o,
    output logic        req_ready,
    output logic        rd_valid,
    output logic        accept,
    output logic        bypass,
    output logic        take_dir,
    output logic        take_tbl,
    output logic        fault_o
);
    walk_state_t state_q;
    logic        issued_q;
    logic        fault_q;
    logic        fetching;
    logic        take_rsp;

    // Handshake decode for the request, read and response ports
    always_comb begin
        req_ready = (state_q == WALK_IDLE);
        accept    = req_ready && req_valid;
        bypass    = accept && !xlat_en;
        fetching  = (state_q == WALK_DIR) || (state_q == WALK_TBL);
        rd_valid  = fetching && !issued_q;
        take_rsp  = fetching && issued_q && rsp_valid;
        take_dir  = take_rsp && (state_q == WALK_DIR);
        take_tbl  = take_rsp && (state_q == WALK_TBL);
    end

    // Phase transitions, outstanding-read tracking and fault capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= WALK_IDLE;
            issued_q <= 1'b0;
            fault_q  <= 1'b0;
        end else begin
            if (rd_valid && rd_ready) begin
                issued_q <= 1'b1;
            end
            case (state_q)
                WALK_IDLE: begin
                    if (accept) begin
                        fault_q <= 1'b0;
                        state_q <= xlat_en ? WALK_DIR : WALK_DONE;
                    end
                end
                WALK_DIR: begin
                    if (take_dir) begin
                        issued_q <= 1'b0;
                        if (rsp_present) begin
                            state_q <= WALK_TBL;
                        end else begin
                            fault_q <= 1'b1;
                            state_q <= WALK_DONE;
                        end
                    end
                end
                WALK_TBL: begin
                    if (take_tbl) begin
                        issued_q <= 1'b0;
                        fault_q  <= !rsp_present;
                        state_q  <= WALK_DONE;
                    end
                end
                default: begin
                    state_q <= WALK_IDLE;
                end
            endcase
        end
    end

    assign state_o = state_q;
    assign fault_o = fault_q;

    // R9: the result phase never lasts more than one cycle
    p_done_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WALK_DONE) |=> (state_q == WALK_IDLE));

    // R5: a missing directory entry goes straight to the result phase
    p_dir_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_dir && !rsp_present) |=> (state_q == WALK_DONE) && fault_q);
endmodule

// File: rtl/pgw_path.sv
// Walk datapath: holds the captured request, forms the entry addresses
// and builds the physical address. Assumes ADDR_W = OFF_W + 2*IDX_W and
// that entries are 4 bytes wide (OFF_W - IDX_W = 2).
module pgw_path #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              bypass,
    input  logic              take_dir,
    input  logic              take_tbl,
    input  logic              sel_tbl,
    input  logic              rsp_present,
    input  logic [ADDR_W-1:0] req_lin,
    input  logic [ADDR_W-OFF_W-1:0] dir_frame,
    input  logic [ADDR_W-OFF_W-1:0] rsp_frame,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] phys
);
    localparam int BASE_W = ADDR_W - OFF_W;
    localparam int PAD_W  = OFF_W - IDX_W;

    logic [ADDR_W-1:0] lin_q;
    logic [BASE_W-1:0] dframe_q;
    logic [BASE_W-1:0] tframe_q;
    logic [ADDR_W-1:0] phys_q;
    logic [IDX_W-1:0]  dir_idx;
    logic [IDX_W-1:0]  tbl_idx;
    logic [ADDR_W-1:0] dir_addr;
    logic [ADDR_W-1:0] tbl_addr;

    // Entry addresses from the captured frames and linear-address indices
    always_comb begin
        dir_idx  = lin_q[ADDR_W-1 -: IDX_W];
        tbl_idx  = lin_q[OFF_W +: IDX_W];
        dir_addr = {dframe_q, dir_idx, {PAD_W{1'b0}}};
        tbl_addr = {tframe_q, tbl_idx, {PAD_W{1'b0}}};
        rd_addr  = sel_tbl ? tbl_addr : dir_addr;
    end

    // Capture request, table frame and final physical address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_q    <= '0;
            dframe_q <= '0;
            tframe_q <= '0;
            phys_q   <= '0;
        end else begin
            if (accept) begin
                lin_q    <= req_lin;
                dframe_q <= dir_frame;
                phys_q   <= bypass ? req_lin : '0;
            end
            if (take_dir) begin
                tframe_q <= rsp_frame;
            end
            if (take_tbl) begin
                phys_q <= rsp_present ? {rsp_frame, lin_q[OFF_W-1:0]} : '0;
            end
        end
    end

    assign phys = phys_q;

    // R2: the captured request stays put until the next accept
    p_lin_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(lin_q));
endmodule

// File: rtl/pgwalk_top.sv
// Two-level address walker top: wires sequencer and datapath to the
// request, memory and result ports. Assumes a memory that returns one
// response per accepted read; only one read is ever outstanding.
module pgwalk_top #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlat_en,
    input  logic [ADDR_W-1:0] dir_base,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_lin,
    output logic              req_ready,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ready,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              res_valid,
    output logic [ADDR_W-1:0] res_phys,
    output logic              res_fault
);
    import pgw_pkg::*;

    localparam int BASE_W = ADDR_W - OFF_W;

    walk_state_t state;
    logic        accept;
    logic        bypass;
    logic        take_dir;
    logic        take_tbl;
    logic        present;
    logic        unused_ctrl;

    assign present     = mem_rsp_data[0];
    assign unused_ctrl = ^{mem_rsp_data[OFF_W-1:1], dir_base[OFF_W-1:0]};

    pgw_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .xlat_en     (xlat_en),
        .rd_ready    (mem_rd_ready),
        .rsp_valid   (mem_rsp_valid),
        .rsp_present (present),
        .state_o     (state),
        .req_ready   (req_ready),
        .rd_valid    (mem_rd_valid),
        .accept      (accept),
        .bypass      (bypass),
        .take_dir    (take_dir),
        .take_tbl    (take_tbl),
        .fault_o     (res_fault)
    );

    pgw_path #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .OFF_W  (OFF_W)
    ) u_path (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .bypass      (bypass),
        .take_dir    (take_dir),
        .take_tbl    (take_tbl),
        .sel_tbl     (state == WALK_TBL),
        .rsp_present (present),
        .req_lin     (req_lin),
        .dir_frame   (dir_base[ADDR_W-1:OFF_W]),
        .rsp_frame   (mem_rsp_data[ADDR_W-1 -: BASE_W]),
        .rd_addr     (mem_rd_addr),
        .phys        (res_phys)
    );

    // Result strobe is the one-cycle result phase
    assign res_valid = (state == WALK_DONE);

    // R8: a pending read keeps its request and address until taken
    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> mem_rd_valid && $stable(mem_rd_addr));

    // R9: result strobe is a single-cycle pulse
    p_res_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R7: no new request is taken while a read is pending
    p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !req_ready);

    // R1: translation off returns the linear address next cycle, no fault
    p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xlat_en) |=>
            res_valid && !res_fault && (res_phys == $past(req_lin)) && !mem_rd_valid);

    // R5: a faulted result carries a zero address
    p_fault_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> (res_phys == '0));
endmodule

// File: tb/pgwalk_top_tb_top.sv
`timescale 1ns/1ps
module pgwalk_top_tb_top;
    typedef struct packed {
        logic        pg;
        logic [31:0] base;
        logic [31:0] lin;
        logic [31:0] pde;
        logic [31:0] pte;
        logic [3:0]  stall;
        logic        hold;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h0010_0000, 32'h1234_5678, 32'h0020_0007, 32'h0ABC_D063, 4'd0, 1'b0},
        '{1'b0, 32'h0055_5000, 32'hDEAD_BEEF, 32'h0000_0001, 32'h0000_0001, 4'd0, 1'b0},
        '{1'b1, 32'h0040_0000, 32'h8765_4321, 32'h0030_0FFE, 32'h0000_0001, 4'd0, 1'b0},
        '{1'b1, 32'h0040_0000, 32'h0040_3ABC, 32'h0031_0001, 32'h1111_1FFE, 4'd0, 1'b0},
        '{1'b1, 32'hFFFF_FABC, 32'hFFFF_FFFF, 32'hFFFF_FFF1, 32'h8000_0FFF, 4'd3, 1'b0},
        '{1'b1, 32'h0000_0000, 32'h0000_0000, 32'h0000_1001, 32'h0000_2001, 4'd1, 1'b0},
        '{1'b1, 32'h00AB_C123, 32'h3FC0_1A5A, 32'h7777_7E03, 32'h5555_5A01, 4'd2, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlat_en = 1'b0;
    logic [31:0] dir_base = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_lin = '0;
    logic        req_ready;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid;
    logic [31:0] res_phys;
    logic        res_fault;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    pgwalk_top dut_i (
        .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .dir_base(dir_base),
        .req_valid(req_valid), .req_lin(req_lin), .req_ready(req_ready),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ready(mem_rd_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .res_valid(res_valid),
        .res_phys(res_phys), .res_fault(res_fault)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Run one walk with a scripted memory; returns what the ports showed
    task automatic run_walk(input vec_t v, output int nreads,
                            output logic [31:0] a0, output logic [31:0] a1,
                            output logic [31:0] phys, output logic flt,
                            output int nres, output int busy_ready);
        int stall_left;
        bit pend;
        nreads = 0; a0 = '0; a1 = '0; phys = '0; flt = 1'b0; nres = 0; busy_ready = 0;
        stall_left = v.stall;
        pend = 1'b0;
        @(negedge clk);
        xlat_en   = v.pg;
        dir_base  = v.base;
        req_lin   = v.lin;
        req_valid = 1'b1;
        @(negedge clk);
        if (v.hold) req_lin = v.lin ^ 32'h0000_0FFF;
        else req_valid = 1'b0;
        for (int cyc = 0; cyc < 60; cyc++) begin
            mem_rsp_valid = 1'b0;
            mem_rd_ready  = 1'b0;
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = (nreads == 1) ? v.pde : v.pte;
                pend = 1'b0;
            end
            if (res_valid) begin
                nres++;
                phys = res_phys;
                flt  = res_fault;
                req_valid = 1'b0;
                break;
            end
            if (mem_rd_valid) begin
                if (req_ready) busy_ready++;
                if (stall_left > 0) begin
                    stall_left--;
                end else begin
                    mem_rd_ready = 1'b1;
                    if (nreads == 0) a0 = mem_rd_addr; else a1 = mem_rd_addr;
                    nreads++;
                    pend = 1'b1;
                end
            end
            @(negedge clk);
        end
        mem_rsp_valid = 1'b0;
        mem_rd_ready  = 1'b0;
        req_valid     = 1'b0;
        // one more cycle: pulse must be gone, nothing restarted
        @(negedge clk);
        if (res_valid) nres++;
        if (mem_rd_valid) nreads++;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int nreads, nres, busy;
        logic [31:0] a0, a1, phys;
        logic flt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(req_ready == 1'b1, "R9 reset req_ready", {31'd0, req_ready}, 32'd1);
        check(mem_rd_valid == 1'b0, "R9 reset mem_rd_valid", {31'd0, mem_rd_valid}, 32'd0);
        check(res_valid == 1'b0, "R9 reset res_valid", {31'd0, res_valid}, 32'd0);

        // Vector table walk: R1..R8
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [31:0] e_dir, e_tbl, e_phys;
            int e_reads;
            logic e_flt;
            v = VECS[i];
            e_dir   = {v.base[31:12], v.lin[31:22], 2'b00};
            e_tbl   = {v.pde[31:12], v.lin[21:12], 2'b00};
            e_reads = !v.pg ? 0 : (!v.pde[0] ? 1 : 2);
            e_flt   = v.pg && (!v.pde[0] || !v.pte[0]);
            e_phys  = !v.pg ? v.lin : (e_flt ? 32'd0 : {v.pte[31:12], v.lin[11:0]});
            run_walk(v, nreads, a0, a1, phys, flt, nres, busy);
            check(nres == 1, "R9 one result pulse", nres, 1);
            check(nreads == e_reads, "R1 R5 R6 R8 read count", nreads, e_reads);
            if (e_reads >= 1) check(a0 == e_dir, "R2 directory entry address", a0, e_dir);
            if (e_reads == 2) check(a1 == e_tbl, "R3 table entry address", a1, e_tbl);
            check(phys == e_phys, "R4 R5 R6 R1 physical address", phys, e_phys);
            check(flt == e_flt, "R4 R5 R6 fault flag", {31'd0, flt}, {31'd0, e_flt});
            check(busy == 0, "R7 ready low while walking", busy, 0);
        end

        // R10: stray response while idle must be ignored
        @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = 32'h0000_0000;
        @(negedge clk);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        check(res_valid == 1'b0, "R10 no result from stray response", {31'd0, res_valid}, 32'd0);
        check(req_ready == 1'b1, "R10 still idle after stray response", {31'd0, req_ready}, 32'd1);
        run_walk(VECS[0], nreads, a0, a1, phys, flt, nres, busy);
        check(nreads == 2, "R10 walk after stray response reads", nreads, 2);
        check(phys == 32'h0ABC_D678, "R10 walk after stray response phys", phys, 32'h0ABC_D678);
        check(flt == 1'b0, "R10 walk after stray response fault", {31'd0, flt}, 32'd0);

        // R1: bypass straight after a faulting walk clears the fault
        run_walk(VECS[2], nreads, a0, a1, phys, flt, nres, busy);
        run_walk(VECS[1], nreads, a0, a1, phys, flt, nres, busy);
        check(flt == 1'b0 && phys == 32'hDEAD_BEEF, "R1 bypass after fault", phys, 32'hDEAD_BEEF);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule